// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between the load/store stage of a 32-bit processor datapath and a word-wide data memory whose read data returns one clock after the request. For each access it adds a sign-extended 16-bit displacement to a base register value to form the byte address. It then checks that the address suits the access size: byte, halfword or word. When the access is aligned, the request goes to memory in the same cycle, so an aligned access costs no extra cycle.

Stores place the low byte or low halfword of the source register on the byte lanes that the address selects, with lane 3 (bits 31:24) holding the lowest address of a word. Stores drive one enable bit per lane. Loads save the address offset, the size and the unsigned flag while the memory read is in flight. When the word returns, the unit picks the addressed lanes and widens the value to 32 bits by sign or by zero. A misaligned access raises a trap. A trapped access reaches no memory and yields no load result.

Top module: `be_lsu_align`

## Requirements
- R1: The memory address equals base_val plus offset_imm sign-extended from 16 to 32 bits, modulo 2^32.
- R2: The size code is 00 for byte, 01 for halfword, 10 for word, and 11 is reserved. trap_misalign is high exactly when req_valid is high and one of these holds: a halfword has address bit 0 set, a word has address bits 1:0 nonzero, or the size code is 11.
- R3: While trap_misalign is high, mem_req, mem_we and all four mem_be bits are low. A trapped load produces no load_valid on the following cycle.
- R4: For an aligned store, mem_be bit 3 is the lane at address offset 0 and bit 0 is the lane at offset 3. A byte store at offset k enables only bit 3-k. A halfword store at offset 0 enables 1100 and at offset 2 enables 0011. A word store enables 1111. Loads and idle cycles drive mem_be to 0000.
- R5: Store data carries store_src[7:0] (byte) or store_src[15:0] (halfword), with the more significant byte on the lower address. A word store carries store_src unchanged. Lanes that are not enabled carry zero.
- R6: An accepted load (req_valid, not a store, no trap) raises mem_req with mem_we low. One cycle later load_valid is high for exactly that cycle, and load_result is formed from mem_rdata of that cycle.
- R7: A byte load returns the lane at its address offset. With req_unsigned low, bit 7 of that byte is copied into bits 31:8. With req_unsigned high, bits 31:8 are zero.
- R8: A halfword load returns the two lanes at its offset, the lower address in bits 15:8. It is sign-extended from bit 15 when req_unsigned is low and zero-extended when req_unsigned is high.
- R9: A word load returns mem_rdata unchanged, and req_unsigned has no effect on it.
- R10: After a synchronous active-low reset, load_valid is low until a load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | Zero-extend a load instead of sign-extending it |
| base_val | input | 32 | Base register value |
| offset_imm | input | 16 | Signed displacement |
| store_src | input | 32 | Store source register |
| mem_addr | output | 32 | Effective byte address |
| mem_req | output | 1 | Memory access issued |
| mem_we | output | 1 | Memory write |
| mem_be | output | 4 | Byte-lane write enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read word, valid one cycle after a read request |
| load_valid | output | 1 | Load result valid |
| load_result | output | 32 | Extracted and extended load value |
| trap_misalign | output | 1 | Misaligned or reserved-size access |

## Verification
The hardest case to reach from the ports is a load result whose value depends on lane choice, extension and prior stores all at once. Only a wrong lane paired with distinctive bytes shows up as a mismatch. The bench fills memory with words whose bytes carry both sign states. It overwrites selected lanes with byte and halfword stores, then reads every offset at every size with both extension modes. It predicts every result from a byte-level shadow of memory.

Displacements alternate between positive and negative values so that the address adder's sign-extension path is exercised. Misaligned and reserved-size accesses are mixed into the sweep. After each of them the bench checks that nothing was written and that no load result appears.

// File: rtl/be_lsu_pkg.sv
// Shared definitions for the big-endian load/store alignment unit.
// Assumes a 32-bit datapath built from 8-bit byte lanes.
package be_lsu_pkg;
    localparam int DATA_W  = 32;
    localparam int OFF_W   = 16;
    localparam int LANE_W  = 8;
    localparam int NLANE   = DATA_W / LANE_W;
    localparam int LOFF_W  = $clog2(NLANE);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;
endpackage

// File: rtl/be_lsu_addr.sv
// Forms the effective byte address and flags misalignment.
// Assumes the displacement is two's complement and that size code 11 is reserved.
module be_lsu_addr
    import be_lsu_pkg::*;
(
    input  logic [DATA_W-1:0] base_val,
    input  logic [OFF_W-1:0]  offset_imm,
    input  acc_size_e         size,
    output logic [DATA_W-1:0] eff_addr,
    output logic              misaligned
);
    logic [DATA_W-1:0] disp_ext;

    // Sign-extend the displacement and add it to the base.
    always_comb begin
        disp_ext = {{(DATA_W-OFF_W){offset_imm[OFF_W-1]}}, offset_imm};
        eff_addr = base_val + disp_ext;
    end

    // An access of S bytes is legal only when the address is a multiple of S.
    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = eff_addr[0];
            SZ_WORD: misaligned = |eff_addr[LOFF_W-1:0];
            default: misaligned = 1'b1;
        endcase
    end
endmodule

// File: rtl/be_lsu_store.sv
// Steers store data onto big-endian byte lanes and builds the lane enables.
// Assumes the caller already masks the request with the trap; lane NLANE-1
// holds the lowest address of a word.
module be_lsu_store
    import be_lsu_pkg::*;
(
    input  logic              wr_go,
    input  acc_size_e         size,
    input  logic [LOFF_W-1:0] loff,
    input  logic [DATA_W-1:0] src,
    output logic [NLANE-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam logic [LOFF_W-1:0] LANE_OFF = LOFF_W'(NLANE - 1 - g);
        logic              hit;
        logic [LANE_W-1:0] byte_v;

        // Decide whether this lane is written and which source byte lands in it.
        always_comb begin
            hit    = 1'b0;
            byte_v = '0;
            unique case (size)
                SZ_BYTE: begin
                    hit    = (loff == LANE_OFF);
                    byte_v = src[LANE_W-1:0];
                end
                SZ_HALF: begin
                    hit    = (loff[LOFF_W-1:1] == LANE_OFF[LOFF_W-1:1]);
                    byte_v = LANE_OFF[0] ? src[LANE_W-1:0] : src[2*LANE_W-1:LANE_W];
                end
                SZ_WORD: begin
                    hit    = 1'b1;
                    byte_v = src[g*LANE_W +: LANE_W];
                end
                default: begin
                    hit    = 1'b0;
                    byte_v = '0;
                end
            endcase
        end

        // Drive the enable and zero the data of lanes that are not written.
        always_comb begin
            be[g]                     = wr_go & hit;
            wdata[g*LANE_W +: LANE_W] = (wr_go & hit) ? byte_v : '0;
        end
    end
endmodule

// File: rtl/be_lsu_load.sv
// Holds the access shape of an outstanding load and extracts the result
// from the returned word. Assumes the memory answers exactly one cycle
// after the read request.
module be_lsu_load
    import be_lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  acc_size_e         size,
    input  logic              uns,
    input  logic [LOFF_W-1:0] loff,
    input  logic [DATA_W-1:0] rdata,
    output logic              load_valid,
    output logic [DATA_W-1:0] load_result
);
    acc_size_e         size_q;
    logic              uns_q;
    logic [LOFF_W-1:0] loff_q;
    logic [DATA_W-1:0] byte_shift;
    logic [DATA_W-1:0] half_shift;
    logic [LANE_W-1:0]   byte_v;
    logic [2*LANE_W-1:0] half_v;

    // Record the shape of an accepted load until its data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_valid <= 1'b0;
            size_q     <= SZ_WORD;
            uns_q      <= 1'b0;
            loff_q     <= '0;
        end else begin
            load_valid <= rd_go;
            if (rd_go) begin
                size_q <= size;
                uns_q  <= uns;
                loff_q <= loff;
            end
        end
    end

    // Move the addressed lanes to the bottom of the word: lowest address sits highest.
    always_comb begin
        byte_shift = rdata >> (LANE_W * (NLANE - 1 - int'(loff_q)));
        half_shift = rdata >> (LANE_W * (NLANE - 2 - 2 * int'(loff_q[LOFF_W-1:1])));
        byte_v     = byte_shift[LANE_W-1:0];
        half_v     = half_shift[2*LANE_W-1:0];
    end

    // Widen to the full word by sign or by zero.
    always_comb begin
        unique case (size_q)
            SZ_BYTE: load_result = {{(DATA_W-LANE_W){byte_v[LANE_W-1] & ~uns_q}}, byte_v};
            SZ_HALF: load_result = {{(DATA_W-2*LANE_W){half_v[2*LANE_W-1] & ~uns_q}}, half_v};
            default: load_result = rdata;
        endcase
    end

    // R6
    resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> $past(rd_go));
    // R7
    sbyte_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && size_q == SZ_BYTE && !uns_q) |->
        (load_result[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){load_result[LANE_W-1]}}));
    // R8
    uhalf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && size_q == SZ_HALF && uns_q) |->
        (load_result[DATA_W-1:2*LANE_W] == '0));
    // R9
    word_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && size_q == SZ_WORD) |-> (load_result == rdata));
endmodule

// File: rtl/be_lsu_align.sv
// Top of the big-endian load/store alignment unit: address formation,
// alignment trap, store lane steering and load extraction.
// Assumes a word-wide memory with one-cycle read latency.
module be_lsu_align
    import be_lsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_is_store,
    input  logic [1:0]  req_size,
    input  logic        req_unsigned,
    input  logic [31:0] base_val,
    input  logic [15:0] offset_imm,
    input  logic [31:0] store_src,
    output logic [31:0] mem_addr,
    output logic        mem_req,
    output logic        mem_we,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        load_valid,
    output logic [31:0] load_result,
    output logic        trap_misalign
);
    acc_size_e size_e;
    logic      misaligned;
    logic      go;

    // Interpret the size code.
    always_comb size_e = acc_size_e'(req_size);

    be_lsu_addr u_addr (
        .base_val   (base_val),
        .offset_imm (offset_imm),
        .size       (size_e),
        .eff_addr   (mem_addr),
        .misaligned (misaligned)
    );

    // Gate the request with the alignment result.
    always_comb begin
        trap_misalign = req_valid & misaligned;
        go            = req_valid & ~misaligned;
        mem_req       = go;
        mem_we        = go & req_is_store;
    end

    be_lsu_store u_store (
        .wr_go (go & req_is_store),
        .size  (size_e),
        .loff  (mem_addr[LOFF_W-1:0]),
        .src   (store_src),
        .be    (mem_be),
        .wdata (mem_wdata)
    );

    be_lsu_load u_load (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_go       (go & ~req_is_store),
        .size        (size_e),
        .uns         (req_unsigned),
        .loff        (mem_addr[LOFF_W-1:0]),
        .rdata       (mem_rdata),
        .load_valid  (load_valid),
        .load_result (load_result)
    );

    // R3
    trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_misalign |-> (!mem_req && !mem_we && mem_be == 4'b0000));
    // R2
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_size == 2'b10) |-> (mem_addr[1:0] == 2'b00));
    // R4
    byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && req_size == 2'b00) |-> ($countones(mem_be) == 1));
    // R4
    read_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> (mem_be == 4'b0000));
endmodule

// File: tb/tb_be_lsu_align.sv
module tb_be_lsu_align;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_is_store, req_unsigned;
    logic [1:0]  req_size;
    logic [31:0] base_val, store_src, mem_addr, mem_wdata, mem_rdata, load_result;
    logic [15:0] offset_imm;
    logic        mem_req, mem_we, load_valid, trap_misalign;
    logic [3:0]  mem_be;

    int n_chk = 0;
    int n_bad = 0;
    int n_cyc = 0;

    logic [31:0] mem_w [16];
    logic [7:0]  shadow [64];

    be_lsu_align dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Word memory model with one-cycle read latency and byte-lane writes.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) mem_w[mem_addr[5:2]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
            end else begin
                mem_rdata <= mem_w[mem_addr[5:2]];
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > WDOG_LIMIT) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", n_cyc, WDOG_LIMIT);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One access: check the request cycle, then the cycle after.
    task automatic access(input bit st, input logic [1:0] sz, input bit uns,
                          input logic [31:0] addr, input bit neg_disp, input logic [31:0] src);
        int          nb;
        bit          mis;
        logic [3:0]  exp_be;
        logic [31:0] exp_wd, exp_ld, raw;
        logic [31:0] base;
        logic [15:0] disp;
        int          a;
        nb  = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        mis = (sz == 2'b11) || (addr % nb != 0);
        disp = neg_disp ? 16'hFFC0 : 16'h0024;
        base = addr - {{16{disp[15]}}, disp};
        a    = int'(addr[5:0]);
        exp_be = '0;
        exp_wd = '0;
        if (st && !mis) begin
            for (int j = 0; j < nb; j++) begin
                int lane = 3 - ((a % 4) + j);
                exp_be[lane] = 1'b1;
                exp_wd[lane*8 +: 8] = src[(nb-1-j)*8 +: 8];
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_is_store = st; req_size = sz; req_unsigned = uns;
        base_val = base; offset_imm = disp; store_src = src;
        #1;
        chk(mem_addr == addr, "R1 effective address", mem_addr, addr);
        chk(trap_misalign == mis, "R2 alignment trap", {31'd0, trap_misalign}, {31'd0, mis});
        if (mis)
            chk(!mem_req && !mem_we && mem_be == 0, "R3 trap suppresses access",
                {mem_req, mem_we, mem_be}, 32'd0);
        else
            chk(mem_req && mem_we == st, "R6 request issued", {mem_req, mem_we}, {1'b1, st});
        chk(mem_be == exp_be, "R4 byte enables", {28'd0, mem_be}, {28'd0, exp_be});
        if (st) chk(mem_wdata == exp_wd, "R5 store lane data", mem_wdata, exp_wd);
        if (st && !mis)
            for (int j = 0; j < nb; j++) shadow[a + j] = src[(nb-1-j)*8 +: 8];
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (!st && !mis) begin
            raw = '0;
            for (int j = 0; j < nb; j++) raw = (raw << 8) | {24'd0, shadow[a + j]};
            if (nb == 1)      exp_ld = uns ? raw : {{24{raw[7]}}, raw[7:0]};
            else if (nb == 2) exp_ld = uns ? raw : {{16{raw[15]}}, raw[15:0]};
            else              exp_ld = raw;
            chk(load_valid == 1'b1, "R6 load_valid after accept", {31'd0, load_valid}, 32'd1);
            chk(load_result == exp_ld, nb == 1 ? "R7 byte load" : nb == 2 ? "R8 halfword load" : "R9 word load",
                load_result, exp_ld);
        end else begin
            chk(load_valid == 1'b0, "R3 no load result", {31'd0, load_valid}, 32'd0);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem_w[i] = '0;
        for (int i = 0; i < 64; i++) shadow[i] = '0;
        mem_rdata = '0;
        rst_n = 1'b0; req_valid = 1'b0; req_is_store = 1'b0; req_size = 2'b00;
        req_unsigned = 1'b0; base_val = '0; offset_imm = '0; store_src = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(load_valid == 1'b0, "R10 reset load_valid", {31'd0, load_valid}, 32'd0);
        chk(!mem_req && !trap_misalign && mem_be == 0, "R3 idle outputs",
            {mem_req, trap_misalign, mem_be}, 32'd0);

        // Fill 8 words with mixed-sign bytes.
        for (int w = 0; w < 8; w++)
            access(1'b1, 2'b10, 1'b0, 32'h0000_2000 + w*4, w[0],
                   32'h80F1_7F02 ^ (w * 32'h1122_3344));

        // Store sweep over sizes and offsets, including traps and reserved size.
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 4; k++)
                access(1'b1, s[1:0], 1'b0, 32'h0000_2010 + s*4 + k, k[0],
                       32'hC3A5_96E8 + s*32'h0101 + k*32'h4040);

        // Load sweep: every size, offset and extension mode over all words.
        for (int w = 0; w < 8; w++)
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 4; k++)
                    for (int u = 0; u < 2; u++)
                        access(1'b0, s[1:0], u[0], 32'h0000_2000 + w*4 + k, u[0] ^ w[0], 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule